// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps the machine-check reporting state of one processor core: a set of error banks and three global registers. Each bank holds a control word, a status word, an address word and a miscellaneous word, all 64 bits wide. The global registers are a capability word, a control word and a status word. A parameter fixes how many banks have storage. The capability word says how many of them are live, and whether the global control word takes part in gating.

An error source offers one injection per cycle. Each injection carries a bank number, a status word, a global status word, an address, a misc word, an "unconditional" flag and a "broadcast" flag. The logger first checks that the request is well formed. It then applies the ordering rules between corrected and uncorrected errors. As a result it either writes the bank, raises a machine-check interrupt pulse, requests a system reset, or drops the request. A two-bit result code reports the outcome on the cycle after the request.

The logger also decodes a processor version word into a flag that tells whether broadcast injections are allowed. A simple write port and a combinational read port give access to every register.

Top module: `mce_bank_logger`

## Requirements
- R1: A request is rejected when the capability word is zero, when the bank number is not below its low 8 bits (the live bank count), or when the bank number is not below the number of banks with storage.
- R2: A request whose status bit 63 (valid) is clear is rejected and changes no register.
- R3: While global status bit 2 (check in progress) is set, a request that has neither status bit 55 (action required) nor the unconditional flag set is dropped.
- R4: An uncorrected request (status bit 61 set) is dropped when capability bit 8 is set and the global control word is not all ones, or when the addressed bank's control word is not all ones.
- R5: An uncorrected request that survives R4 requests a reset instead of logging when global status bit 2 is already set or when `mc_enable` is low. It then writes no register.
- R6: An accepted uncorrected request writes address, misc, the bank status and the global status, and pulses `mce_irq`. The stored status has bit 62 (overflow) set if the bank already held a valid entry.
- R7: A corrected request overwrites the bank's address, misc and status when the bank is empty or holds a corrected entry, and sets overflow if the old entry was valid. When the bank holds a valid uncorrected entry, only bit 62 of that entry is set, and address and misc are kept.
- R8: `bcast_ok` is high when the family (version bits 11:8) is above 6, or is 6 with a model of 14 or more. The model is version bits 19:16 as the high nibble and bits 7:4 as the low nibble. A request with the broadcast flag set while `bcast_ok` is low is rejected.
- R9: For each request, `res_valid` is high for exactly the next cycle, with `res_code` 0 for accepted, 1 for dropped, 2 for rejected and 3 for reset requested. `mce_irq` and `reset_req` pulse in that same cycle only.
- R10: Register addresses are 0 for capability, 1 for global control and 2 for global status. Bank b uses 4+4b for control, 5+4b for status, 6+4b for address and 7+4b for misc. Writes through the configuration port are read back unchanged, and the capability word resets to `CAP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_enable | input | 1 | Machine-check enable from the core's control state |
| cpu_version | input | 32 | Processor version word |
| bcast_ok | output | 1 | Broadcast injections are allowed |
| inj_valid | input | 1 | Injection request present |
| inj_bank | input | 8 | Target bank number |
| inj_status | input | 64 | Bank status to log |
| inj_gstatus | input | 64 | Global status to log |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Miscellaneous error word |
| inj_uncond | input | 1 | Log even while a check is in progress |
| inj_bcast | input | 1 | Request is a broadcast injection |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | clog2(4+4*NBANK) | Register write address |
| cfg_wdata | input | 64 | Register write data |
| rd_addr | input | clog2(4+4*NBANK) | Register read address |
| rd_data | output | 64 | Register read data |
| res_valid | output | 1 | Result code valid |
| res_code | output | 2 | Request outcome |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
Corrected requests go to an empty bank, to a bank holding a corrected entry and to a bank holding an uncorrected entry. These three cases separate a plain overwrite, an overwrite with overflow, and marking the old entry with overflow only.

Uncorrected requests are tried with the global control word, the bank control word, the enable input and the in-progress flag each blocking in turn. This shows that the drop cases and the reset escalation come from the right conditions and in the right priority.

Malformed requests (bank out of range, zero capability, valid bit clear, broadcast without eligibility) and version words on both sides of the family/model threshold exercise rejection. A long run of random requests interleaved with control writes is then compared against a behavioural model on every cycle.

// File: rtl/mce_log_pkg.sv
package mce_log_pkg;
    localparam int W = 64;
    // bank status bit positions
    localparam int ST_VALID  = 63;
    localparam int ST_OVER   = 62;
    localparam int ST_UNCORR = 61;
    localparam int ST_ACTREQ = 55;
    // global status bit positions
    localparam int GS_RIPV   = 0;
    localparam int GS_INPROG = 2;
    // capability: bank count in [7:0], global control present flag
    localparam int CAP_GCTL_BIT = 8;

    typedef enum logic [1:0] {
        RES_ACCEPT = 2'd0,
        RES_DROP   = 2'd1,
        RES_REJECT = 2'd2,
        RES_RESET  = 2'd3
    } res_code_e;

    typedef struct packed {
        res_code_e    code;
        logic         wr_status;
        logic         wr_data;
        logic         wr_gstat;
        logic         irq;
        logic         rst;
        logic [W-1:0] status;
    } decide_t;
endpackage

// File: rtl/mce_bcast_check.sv
module mce_bcast_check (
    input  logic [31:0] version,
    output logic        eligible
);
    logic [3:0] family;
    logic [7:0] model;
    logic       unused_ver;

    assign family     = version[11:8];
    assign model      = {version[19:16], version[7:4]};
    assign eligible   = (family > 4'd6) || ((family == 4'd6) && (model >= 8'd14));
    assign unused_ver = ^{version[31:20], version[3:0]};
endmodule

// File: rtl/mce_inject_decide.sv
module mce_inject_decide
    import mce_log_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap,
    input  logic [W-1:0] gctl,
    input  logic         in_progress,
    input  logic [W-1:0] bank_ctl,
    input  logic [W-1:0] bank_status,
    input  logic [7:0]   bank_idx,
    input  logic [W-1:0] req_status,
    input  logic         req_uncond,
    input  logic         req_bcast,
    input  logic         bcast_ok,
    input  logic         mc_enable,
    output decide_t      dec
);
    logic [7:0] live_count;
    logic       has_gctl;
    logic       malformed;
    logic       gated_off;
    logic       unused_cap;

    assign live_count = cap[7:0];
    assign has_gctl   = cap[CAP_GCTL_BIT];
    assign unused_cap = ^cap[W-1:CAP_GCTL_BIT+1];

    assign malformed = (cap == '0) || (bank_idx >= live_count) ||
                       (bank_idx >= 8'(NBANK)) || !req_status[ST_VALID] ||
                       (req_bcast && !bcast_ok);
    assign gated_off = (has_gctl && !(&gctl)) || !(&bank_ctl);

    always_comb begin
        dec        = '0;
        dec.code   = RES_ACCEPT;
        dec.status = req_status;
        if (malformed) begin
            dec.code = RES_REJECT;
        end else if (!req_uncond && !req_status[ST_ACTREQ] && in_progress) begin
            dec.code = RES_DROP;
        end else if (req_status[ST_UNCORR]) begin
            if (gated_off) begin
                dec.code = RES_DROP;
            end else if (in_progress || !mc_enable) begin
                dec.code = RES_RESET;
                dec.rst  = 1'b1;
            end else begin
                dec.status[ST_OVER] = req_status[ST_OVER] | bank_status[ST_VALID];
                dec.wr_status       = 1'b1;
                dec.wr_data         = 1'b1;
                dec.wr_gstat        = 1'b1;
                dec.irq             = 1'b1;
            end
        end else if (!bank_status[ST_VALID] || !bank_status[ST_UNCORR]) begin
            dec.status[ST_OVER] = req_status[ST_OVER] | bank_status[ST_VALID];
            dec.wr_status       = 1'b1;
            dec.wr_data         = 1'b1;
        end else begin
            dec.status          = bank_status;
            dec.status[ST_OVER] = 1'b1;
            dec.wr_status       = 1'b1;
        end
    end

    // R7: a corrected request never erases a held uncorrected entry
    p_keep_uncorr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!malformed && !req_status[ST_UNCORR] && bank_status[ST_VALID] &&
         bank_status[ST_UNCORR] && dec.wr_status)
        |-> (dec.status[ST_UNCORR] && dec.status[ST_OVER] && !dec.wr_data));

    // R5: reset escalation never writes state
    p_reset_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rst |-> !(dec.wr_status || dec.wr_data || dec.wr_gstat || dec.irq));
endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
    import mce_log_pkg::*;
#(
    parameter int           NBANK    = 4,
    parameter logic [63:0]  CAP_INIT = 64'h104
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mc_enable,
    input  logic [31:0]                   cpu_version,
    output logic                          bcast_ok,
    input  logic                          inj_valid,
    input  logic [7:0]                    inj_bank,
    input  logic [63:0]                   inj_status,
    input  logic [63:0]                   inj_gstatus,
    input  logic [63:0]                   inj_addr,
    input  logic [63:0]                   inj_misc,
    input  logic                          inj_uncond,
    input  logic                          inj_bcast,
    input  logic                          cfg_we,
    input  logic [$clog2(4+4*NBANK)-1:0]  cfg_addr,
    input  logic [63:0]                   cfg_wdata,
    input  logic [$clog2(4+4*NBANK)-1:0]  rd_addr,
    output logic [63:0]                   rd_data,
    output logic                          res_valid,
    output logic [1:0]                    res_code,
    output logic                          mce_irq,
    output logic                          reset_req
);
    localparam int AW    = $clog2(4 + 4*NBANK);
    localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    typedef struct packed {
        logic [W-1:0]            cap;
        logic [W-1:0]            gctl;
        logic [W-1:0]            gstat;
        logic [NBANK-1:0][W-1:0] ctl;
        logic [NBANK-1:0][W-1:0] st;
        logic [NBANK-1:0][W-1:0] addr;
        logic [NBANK-1:0][W-1:0] misc;
        logic                    res_valid;
        res_code_e               res_code;
        logic                    irq;
        logic                    rst;
    } state_t;

    state_t s_d, s_q;

    logic [SEL_W-1:0] sel;
    logic             in_store;
    logic [W-1:0]     sel_ctl;
    logic [W-1:0]     sel_st;
    decide_t          dec;
    logic             elig;

    assign sel      = inj_bank[SEL_W-1:0];
    assign in_store = inj_bank < 8'(NBANK);
    assign sel_ctl  = in_store ? s_q.ctl[sel] : '0;
    assign sel_st   = in_store ? s_q.st[sel]  : '0;

    mce_bcast_check u_bcast (
        .version  (cpu_version),
        .eligible (elig)
    );
    assign bcast_ok = elig;

    mce_inject_decide #(.NBANK(NBANK)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap         (s_q.cap),
        .gctl        (s_q.gctl),
        .in_progress (s_q.gstat[GS_INPROG]),
        .bank_ctl    (sel_ctl),
        .bank_status (sel_st),
        .bank_idx    (inj_bank),
        .req_status  (inj_status),
        .req_uncond  (inj_uncond),
        .req_bcast   (inj_bcast),
        .bcast_ok    (elig),
        .mc_enable   (mc_enable),
        .dec         (dec)
    );

    // next-state: configuration write first, injection outcome on top
    always_comb begin
        s_d           = s_q;
        s_d.res_valid = inj_valid;
        s_d.res_code  = inj_valid ? dec.code : RES_ACCEPT;
        s_d.irq       = inj_valid & dec.irq;
        s_d.rst       = inj_valid & dec.rst;
        if (cfg_we) begin
            case (cfg_addr)
                AW'(0):  s_d.cap   = cfg_wdata;
                AW'(1):  s_d.gctl  = cfg_wdata;
                AW'(2):  s_d.gstat = cfg_wdata;
                default: ;
            endcase
            for (int b = 0; b < NBANK; b++) begin
                if (int'(cfg_addr[AW-1:2]) == b + 1) begin
                    case (cfg_addr[1:0])
                        2'd0: s_d.ctl[b]  = cfg_wdata;
                        2'd1: s_d.st[b]   = cfg_wdata;
                        2'd2: s_d.addr[b] = cfg_wdata;
                        default: s_d.misc[b] = cfg_wdata;
                    endcase
                end
            end
        end
        if (inj_valid && in_store) begin
            if (dec.wr_status) s_d.st[sel]   = dec.status;
            if (dec.wr_data) begin
                s_d.addr[sel] = inj_addr;
                s_d.misc[sel] = inj_misc;
            end
        end
        if (inj_valid && dec.wr_gstat) s_d.gstat = inj_gstatus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cap <= CAP_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    // read port
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(0):  rd_data = s_q.cap;
            AW'(1):  rd_data = s_q.gctl;
            AW'(2):  rd_data = s_q.gstat;
            default: ;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (int'(rd_addr[AW-1:2]) == b + 1) begin
                case (rd_addr[1:0])
                    2'd0: rd_data = s_q.ctl[b];
                    2'd1: rd_data = s_q.st[b];
                    2'd2: rd_data = s_q.addr[b];
                    default: rd_data = s_q.misc[b];
                endcase
            end
        end
    end

    assign res_valid = s_q.res_valid;
    assign res_code  = s_q.res_code;
    assign mce_irq   = s_q.irq;
    assign reset_req = s_q.rst;

    // R6: interrupt only with an accepted result
    p_irq_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mce_irq |-> (res_valid && res_code == RES_ACCEPT));

    // R5: reset request carries its own code and no interrupt
    p_reset_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (res_valid && res_code == RES_RESET && !mce_irq));

    // R9: a result follows exactly one cycle after a request
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |=> res_valid);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_valid |=> !res_valid);

    // R6: global status only moves through an interrupt or a register write
    p_gstat_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !(inj_valid && dec.irq)) |=> $stable(s_q.gstat));

    // R4: a non-accepted request leaves every bank status untouched
    p_nonaccept_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && dec.code != RES_ACCEPT && !cfg_we) |=> $stable(s_q.st));

    // R8: families above 6 are always eligible
    p_family_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_version[11:8] > 4'd6) |-> bcast_ok);
endmodule

// File: tb/mce_bank_logger_tb.sv
module mce_bank_logger_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NB = 4;
    localparam int AW = 5;
    localparam logic [63:0] VAL = 64'h1 << 63;
    localparam logic [63:0] OVR = 64'h1 << 62;
    localparam logic [63:0] UC  = 64'h1 << 61;
    localparam logic [63:0] AR  = 64'h1 << 55;
    localparam logic [63:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          mc_enable = 1'b1;
    logic [31:0]   cpu_version = 32'h0;
    logic          bcast_ok;
    logic          inj_valid = 1'b0;
    logic [7:0]    inj_bank = '0;
    logic [63:0]   inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic          inj_uncond = 1'b0, inj_bcast = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [63:0]   cfg_wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data;
    logic          res_valid;
    logic [1:0]    res_code;
    logic          mce_irq, reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;

    mce_bank_logger #(.NBANK(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .mc_enable(mc_enable), .cpu_version(cpu_version),
        .bcast_ok(bcast_ok), .inj_valid(inj_valid), .inj_bank(inj_bank),
        .inj_status(inj_status), .inj_gstatus(inj_gstatus), .inj_addr(inj_addr),
        .inj_misc(inj_misc), .inj_uncond(inj_uncond), .inj_bcast(inj_bcast),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .res_valid(res_valid),
        .res_code(res_code), .mce_irq(mce_irq), .reset_req(reset_req)
    );

    function automatic bit vers_ok(logic [31:0] v);
        int fam, mdl;
        fam = (int'(v) >> 8) & 15;
        mdl = ((int'(v) >> 12) & 'hf0) + ((int'(v) >> 4) & 15);
        return (fam > 6) || (fam == 6 && mdl >= 14);
    endfunction

    // behavioural reference model
    logic [63:0] m_cap, m_gctl, m_gstat;
    logic [63:0] m_ctl[NB], m_st[NB], m_adr[NB], m_misc[NB];
    logic        e_valid = 0, e_irq = 0, e_rst = 0;
    logic [1:0]  e_code = 0;
    string       e_tag = "R9";

    always @(posedge clk) begin : ref_model
        logic [63:0] old, nst;
        int b;
        bit do_st, do_data, do_g;
        if (!rst_n) begin
            m_cap = 64'h104; m_gctl = 0; m_gstat = 0;
            for (int i = 0; i < NB; i++) begin
                m_ctl[i] = 0; m_st[i] = 0; m_adr[i] = 0; m_misc[i] = 0;
            end
            e_valid = 0; e_irq = 0; e_rst = 0; e_code = 0;
        end else begin
            e_valid = inj_valid; e_irq = 0; e_rst = 0; e_code = 0;
            do_st = 0; do_data = 0; do_g = 0; nst = 0;
            b = int'(inj_bank);
            if (inj_valid) begin
                old = (b < NB) ? m_st[b] : 64'h0;
                if (m_cap == 0 || b >= int'(m_cap[7:0]) || b >= NB) begin
                    e_code = 2; e_tag = "R1";
                end else if (!inj_status[63]) begin
                    e_code = 2; e_tag = "R2";
                end else if (inj_bcast && !vers_ok(cpu_version)) begin
                    e_code = 2; e_tag = "R8";
                end else if (!inj_uncond && !inj_status[55] && m_gstat[2]) begin
                    e_code = 1; e_tag = "R3";
                end else if (inj_status[61]) begin
                    if ((m_cap[8] && m_gctl != ONES) || m_ctl[b] != ONES) begin
                        e_code = 1; e_tag = "R4";
                    end else if (m_gstat[2] || !mc_enable) begin
                        e_code = 3; e_rst = 1; e_tag = "R5";
                    end else begin
                        nst = inj_status | (old[63] ? OVR : 64'h0);
                        do_st = 1; do_data = 1; do_g = 1; e_irq = 1; e_tag = "R6";
                    end
                end else if (!old[63] || !old[61]) begin
                    nst = inj_status | (old[63] ? OVR : 64'h0);
                    do_st = 1; do_data = 1; e_tag = "R7";
                end else begin
                    nst = old | OVR; do_st = 1; e_tag = "R7";
                end
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_cap = cfg_wdata;
                else if (cfg_addr == 1) m_gctl = cfg_wdata;
                else if (cfg_addr == 2) m_gstat = cfg_wdata;
                else if (cfg_addr >= 4 && int'(cfg_addr) < 4 + 4*NB) begin
                    case (cfg_addr % 4)
                        0: m_ctl[cfg_addr/4 - 1] = cfg_wdata;
                        1: m_st[cfg_addr/4 - 1] = cfg_wdata;
                        2: m_adr[cfg_addr/4 - 1] = cfg_wdata;
                        default: m_misc[cfg_addr/4 - 1] = cfg_wdata;
                    endcase
                end
            end
            if (do_st) m_st[b] = nst;
            if (do_data) begin m_adr[b] = inj_addr; m_misc[b] = inj_misc; end
            if (do_g) m_gstat = inj_gstatus;
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R9 timing, codes, pulses, R8 flag)
    always @(negedge clk) begin
        if (started && rst_n) begin
            logic [5:0] act, exp;
            act = {res_valid, res_valid ? res_code : 2'b00, mce_irq, reset_req, bcast_ok};
            exp = {e_valid, e_valid ? e_code : 2'b00, e_irq, e_rst, vers_ok(cpu_version)};
            check(act == exp, {"R9/", e_tag}, 64'(act), 64'(exp));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic inj(int bank, logic [63:0] st, logic [63:0] gst = 64'h5,
                       bit unc = 0, bit bc = 0);
        inj_valid = 1; inj_bank = 8'(bank); inj_status = st; inj_gstatus = gst;
        inj_addr = {32'hADD0_0000, 24'h0, 8'(bank)} ^ st; inj_misc = ~st;
        inj_uncond = unc; inj_bcast = bc;
        step();
        inj_valid = 0; inj_uncond = 0; inj_bcast = 0;
    endtask

    task automatic cfg(int a, logic [63:0] d);
        cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
        step();
        cfg_we = 0;
    endtask

    task automatic rchk(int a, logic [63:0] exp, string tag);
        rd_addr = AW'(a);
        #0.5;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] keep_addr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1; started = 1;
        step();
        // R10 reset state
        rchk(0, 64'h104, "R10 cap reset");
        rchk(2, 64'h0, "R10 gstat reset");
        rchk(5, 64'h0, "R10 bank0 status reset");
        // R7 corrected into empty bank, then overflow
        inj(0, VAL | 64'h11);
        rchk(5, VAL | 64'h11, "R7 corrected into empty");
        inj(0, VAL | 64'h22);
        rchk(5, VAL | OVR | 64'h22, "R7 corrected overflow");
        // R4 gating
        inj(1, VAL | UC | 64'h33);
        rchk(9, 64'h0, "R4 global control gate");
        cfg(1, ONES);
        inj(1, VAL | UC | 64'h33);
        rchk(9, 64'h0, "R4 bank control gate");
        cfg(8, ONES);
        // R5 enable low
        mc_enable = 0;
        inj(1, VAL | UC | 64'h33);
        rchk(9, 64'h0, "R5 disabled no log");
        rchk(2, 64'h0, "R5 disabled gstat");
        mc_enable = 1;
        // R6 accept
        inj(1, VAL | UC | 64'h33, 64'h5);
        rchk(9, VAL | UC | 64'h33, "R6 uncorrected logged");
        rchk(2, 64'h5, "R6 gstat written");
        rd_addr = AW'(10); #0.5; keep_addr = rd_data;
        // R3 drop while in progress
        inj(1, VAL | 64'h44);
        rchk(9, VAL | UC | 64'h33, "R3 dropped");
        // R7 only overflow on held uncorrected
        inj(1, VAL | 64'h44, 64'h0, 1);
        rchk(9, VAL | OVR | UC | 64'h33, "R7 overflow only");
        rchk(10, keep_addr, "R7 address kept");
        // R5 in progress escalation
        inj(1, VAL | UC | AR | 64'h55);
        rchk(9, VAL | OVR | UC | 64'h33, "R5 in progress no log");
        cfg(2, 64'h0);
        inj(1, VAL | UC | AR | 64'h55, 64'h1);
        rchk(9, VAL | OVR | UC | AR | 64'h55, "R6 overflow on valid");
        rchk(2, 64'h1, "R6 gstat");
        // R1 range and capability
        inj(4, VAL | 64'h66);
        cfg(0, 64'h102);
        inj(2, VAL | 64'h66);
        rchk(13, 64'h0, "R1 beyond live count");
        cfg(0, 64'h0);
        inj(0, VAL | 64'h77);
        rchk(5, VAL | OVR | 64'h22, "R1 zero capability");
        cfg(0, 64'h104);
        // R2 valid clear
        inj(3, 64'h88);
        rchk(17, 64'h0, "R2 invalid ignored");
        // R8 broadcast eligibility
        cpu_version = 32'h0000_06D0; step();
        check(bcast_ok == 1'b0, "R8 fam6 model13", 64'(bcast_ok), 64'h0);
        inj(3, VAL | 64'h99, 64'h0, 0, 1);
        rchk(17, 64'h0, "R8 bcast rejected");
        cpu_version = 32'h0000_06E0; step();
        check(bcast_ok == 1'b1, "R8 fam6 model14", 64'(bcast_ok), 64'h1);
        inj(3, VAL | 64'h99, 64'h0, 0, 1);
        rchk(17, VAL | 64'h99, "R8 bcast accepted");
        cpu_version = 32'h0001_0610; step();
        check(bcast_ok == 1'b1, "R8 extended model", 64'(bcast_ok), 64'h1);
        cpu_version = 32'h0000_05F0; step();
        check(bcast_ok == 1'b0, "R8 fam5", 64'(bcast_ok), 64'h0);
        // R10 read back of written words
        cfg(15, 64'hDEAD_BEEF_0123_4567);
        rchk(15, 64'hDEAD_BEEF_0123_4567, "R10 misc readback");
        // random phase against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            mc_enable = ($urandom_range(0, 9) != 0);
            cpu_version = ($urandom_range(0, 1) != 0) ? 32'h0000_06E0 : 32'h0000_0650;
            if (r < 70) begin
                logic [63:0] st;
                st = {$urandom, $urandom};
                st[63] = ($urandom_range(0, 4) != 0);
                inj(int'($urandom_range(0, 5)), st, {$urandom, $urandom},
                    $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0);
            end else if (r < 80) begin
                cfg(2, 64'h0);
            end else if (r < 90) begin
                cfg(4 + 4*int'($urandom_range(0, NB-1)),
                    ($urandom_range(0, 3) != 0) ? ONES : 64'h1);
            end else begin
                step();
            end
            begin
                int bb;
                bb = int'($urandom_range(0, NB-1));
                rchk(5 + 4*bb, m_st[bb], "R7/R6 random status");
            end
        end
        rchk(2, m_gstat, "R6 random gstat");
        step(); step();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule